// File: doc/BRIEF.md
# SWD Host Transaction Engine

This block is the host side of a serial wire debug link. It runs one debug-port or access-port register access for each accepted request. From an access-port select, a read flag and a two-bit register address it builds the 8-bit request header, including its parity. It shifts the header out on SWDIO and releases the line for a turnaround. It then samples the target's three acknowledge bits. After a good acknowledge it moves 32 data bits and a parity bit, toward the target on a write or from the target on a read. It ends with a single-cycle response that carries a status code and, for reads, the data.

Each period of `clk_i` is one SWCLK bit time, and `swclk_en_o` marks the periods in which the clock must toggle. SWDIO is split into a driven value, an output enable and a sampled input. The engine samples `swdio_i` at the rising edge that ends a bit period. A debug-port write to the target-select register returns no acknowledge, so the engine ignores the acknowledge slot for that request. After a successful access-port transfer, the engine can clock a programmable number of idle bits with the line held low.

Top module: `swd_host_xfer`

## Requirements
- R1: The header goes out least significant bit first as start (1), ap, read, addr[0], addr[1], parity, stop (0), park (1). The parity bit is the XOR of ap, read, addr[1] and addr[0].
- R2: `swdio_oe_o` is low in every turnaround bit and in every bit the target drives: bits 8 to 12 of a transfer, and bits 8 to 45 of a read that gets a good acknowledge. It is high in every other bit of a transfer.
- R3: The acknowledge is taken from bits 9, 10 and 11, first bit as bit 0. The value 3'b001 gives status 2'b00 (OK), 3'b010 gives 2'b01 (WAIT) and 3'b100 gives 2'b10 (FAULT). Any other value gives 2'b11 (error).
- R4: A transfer whose acknowledge is not OK has no data phase. It lasts exactly 13 clocked bits: header, turnaround, acknowledge, turnaround.
- R5: A read with OK samples 32 data bits, least significant first, in bits 12 to 43, then a parity bit in bit 44, then one turnaround bit. It lasts 46 bits plus any idle bits. The data is returned on `rsp_rdata_o`. If the 33 sampled bits have odd parity, the status becomes error (2'b11).
- R6: A write with OK has a turnaround in bit 12. It then drives the 32 write data bits, least significant first, in bits 13 to 44, and their even parity bit in bit 45.
- R7: A debug-port write to register address 2'b11 (target select) ignores whatever appears in the acknowledge slot. It always performs the write data phase and always reports OK.
- R8: After an access-port transfer that ends with OK, the engine clocks exactly `idle_cycles_i` extra bits (the value captured at acceptance), with the line driven low. Debug-port transfers and transfers that do not end in OK add none.
- R9: After reset, and whenever the engine is idle, `req_ready_o` is high, `swclk_en_o` is low, and the line is driven low. `req_ready_o` stays low from acceptance until the response. `rsp_valid_o` is a one-cycle pulse, and the engine is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Engine clock, one SWCLK bit per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle, request accepted when valid |
| req_ap_i | input | 1 | 1 selects access port, 0 debug port |
| req_read_i | input | 1 | 1 for read, 0 for write |
| req_addr_i | input | 2 | Register address bits [3:2] |
| req_wdata_i | input | DATA_W | Write data |
| idle_cycles_i | input | IDLE_W | Idle bits after a successful access-port transfer |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_status_o | output | 2 | 00 OK, 01 WAIT, 10 FAULT, 11 error |
| rsp_rdata_o | output | DATA_W | Read data |
| swclk_en_o | output | 1 | SWCLK toggles in this period |
| swdio_o | output | 1 | Value driven on SWDIO |
| swdio_oe_o | output | 1 | SWDIO output enable |
| swdio_i | input | 1 | Sampled SWDIO |

## Verification
The assertions check on every cycle the line state while idle, the start bit that follows each acceptance, the release of the line at the first turnaround, the one-cycle response pulse, and the transfer lengths of short and target-select transactions. Only the bench's scenarios can show the bit-exact header contents, the write data and parity on the wire, the acknowledge decode, the read data and parity-error outcome, and the number of idle bits. The bench sweeps every combination of port, direction and address against five acknowledge patterns.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'b00,
    ST_WAIT  = 2'b01,
    ST_FAULT = 2'b10,
    ST_ERR   = 2'b11
  } xfer_status_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_HDR, PH_TRN_A, PH_ACK, PH_TRN_B,
    PH_WDATA, PH_RDATA, PH_TRN_C, PH_PAD, PH_DONE
  } phase_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam int unsigned HDR_W    = 8;
endpackage

// File: rtl/swd_hdr_build.sv
module swd_hdr_build
  import swd_host_pkg::*;
(
  input  logic             ap_i,
  input  logic             read_i,
  input  logic [1:0]       addr_i,
  output logic [HDR_W-1:0] hdr_o,
  output logic             silent_o
);
  logic par;
  assign par      = ^{ap_i, read_i, addr_i};
  // park, stop, parity, a3, a2, read, ap, start (bit 0 first on wire)
  assign hdr_o    = {1'b1, 1'b0, par, addr_i[1], addr_i[0], read_i, ap_i, 1'b1};
  // target-select write: no reply from target
  assign silent_o = !ap_i && !read_i && (addr_i == 2'b11);
endmodule

// File: rtl/swd_ack_decode.sv
module swd_ack_decode
  import swd_host_pkg::*;
(
  input  logic [2:0]   ack_i,
  output xfer_status_e status_o
);
  always_comb begin
    unique case (ack_i)
      ACK_OK:    status_o = ST_OK;
      ACK_WAIT:  status_o = ST_WAIT;
      ACK_FAULT: status_o = ST_FAULT;
      default:   status_o = ST_ERR;
    endcase
  end
endmodule

// File: rtl/swd_host_xfer.sv
module swd_host_xfer
  import swd_host_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_ap_i,
  input  logic              req_read_i,
  input  logic [1:0]        req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [IDLE_W-1:0] idle_cycles_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              swclk_en_o,
  output logic              swdio_o,
  output logic              swdio_oe_o,
  input  logic              swdio_i
);
  localparam int unsigned SH_W = DATA_W + 1;
  localparam int unsigned CW   = $clog2(SH_W + 1);

  phase_e            phase_q;
  logic [CW-1:0]     cnt_q;
  logic [SH_W-1:0]   sh_q;
  logic [1:0]        ack_q;
  logic [IDLE_W-1:0] pad_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ap_q, rd_q, silent_q;
  xfer_status_e      status_q;

  logic [HDR_W-1:0]  hdr;
  logic              silent;
  logic [2:0]        ack_next;
  xfer_status_e      ack_status;
  logic [SH_W-1:0]   rd_next;
  logic              want_pad;

  swd_hdr_build u_hdr (
    .ap_i    (req_ap_i),
    .read_i  (req_read_i),
    .addr_i  (req_addr_i),
    .hdr_o   (hdr),
    .silent_o(silent)
  );

  assign ack_next = {swdio_i, ack_q};

  swd_ack_decode u_ack (
    .ack_i   (ack_next),
    .status_o(ack_status)
  );

  assign rd_next  = {swdio_i, sh_q[SH_W-1:1]};
  assign want_pad = ap_q && (status_q == ST_OK) && (pad_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      ack_q    <= '0;
      pad_q    <= '0;
      wdata_q  <= '0;
      ap_q     <= 1'b0;
      rd_q     <= 1'b0;
      silent_q <= 1'b0;
      status_q <= ST_OK;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (req_valid_i) begin
          ap_q     <= req_ap_i;
          rd_q     <= req_read_i;
          silent_q <= silent;
          pad_q    <= idle_cycles_i;
          wdata_q  <= req_wdata_i;
          sh_q     <= {{(SH_W-HDR_W){1'b0}}, hdr};
          cnt_q    <= CW'(HDR_W - 1);
          status_q <= ST_OK;
          phase_q  <= PH_HDR;
        end
        PH_HDR: begin
          sh_q <= sh_q >> 1;
          if (cnt_q == '0) phase_q <= PH_TRN_A;
          else cnt_q <= cnt_q - 1'b1;
        end
        PH_TRN_A: begin
          cnt_q   <= CW'(2);
          phase_q <= PH_ACK;
        end
        PH_ACK: begin
          ack_q <= ack_next[2:1];
          if (cnt_q == '0) begin
            status_q <= silent_q ? ST_OK : ack_status;
            if (!silent_q && rd_q && ack_status == ST_OK) begin
              cnt_q   <= CW'(DATA_W);
              phase_q <= PH_RDATA;
            end else begin
              phase_q <= PH_TRN_B;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_TRN_B: begin
          if (!rd_q && status_q == ST_OK) begin
            sh_q    <= {^wdata_q, wdata_q};
            cnt_q   <= CW'(DATA_W);
            phase_q <= PH_WDATA;
          end else begin
            phase_q <= PH_DONE;
          end
        end
        PH_WDATA: begin
          sh_q <= sh_q >> 1;
          if (cnt_q == '0) begin
            pad_q   <= pad_q - 1'b1;
            phase_q <= want_pad ? PH_PAD : PH_DONE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_RDATA: begin
          sh_q <= rd_next;
          if (cnt_q == '0) begin
            if (^rd_next) status_q <= ST_ERR;
            phase_q <= PH_TRN_C;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_TRN_C: begin
          pad_q   <= pad_q - 1'b1;
          phase_q <= want_pad ? PH_PAD : PH_DONE;
        end
        PH_PAD: begin
          if (pad_q == '0) phase_q <= PH_DONE;
          else pad_q <= pad_q - 1'b1;
        end
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (phase_q == PH_IDLE);
  assign rsp_valid_o  = (phase_q == PH_DONE);
  assign rsp_status_o = status_q;
  assign rsp_rdata_o  = sh_q[DATA_W-1:0];
  assign swclk_en_o   = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
  assign swdio_oe_o   = !(phase_q inside {PH_TRN_A, PH_ACK, PH_TRN_B, PH_RDATA, PH_TRN_C});
  assign swdio_o      = (phase_q == PH_HDR || phase_q == PH_WDATA) ? sh_q[0] : 1'b0;
endmodule

// File: rtl/swd_host_xfer_chk.sv
module swd_host_xfer_chk
  import swd_host_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       req_read_i,
  input logic       req_ap_i,
  input logic [1:0] req_addr_i,
  input logic       rsp_valid_o,
  input logic [1:0] rsp_status_o,
  input logic       swclk_en_o,
  input logic       swdio_o,
  input logic       swdio_oe_o
);
  logic [15:0] bits_q;
  logic        busy_q, tsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      busy_q <= 1'b0;
      tsel_q <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      bits_q <= '0;
      busy_q <= 1'b1;
      tsel_q <= !req_ap_i && !req_read_i && (req_addr_i == 2'b11);
    end else begin
      if (swclk_en_o && bits_q != 16'hffff) bits_q <= bits_q + 1'b1;
      if (rsp_valid_o) busy_q <= 1'b0;
    end
  end

  a_r9_idle_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!swclk_en_o && swdio_oe_o && !swdio_o));

  a_r9_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  a_r9_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swclk_en_o |-> !req_ready_o);

  a_r1_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (swclk_en_o && swdio_oe_o && swdio_o));

  a_r2_first_trn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && swclk_en_o && bits_q == 16'd8) |-> !swdio_oe_o);

  a_r4_short_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rsp_valid_o && (rsp_status_o == ST_WAIT || rsp_status_o == ST_FAULT))
      |-> bits_q == 16'd13);

  a_r7_tsel_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rsp_valid_o && tsel_q) |-> (rsp_status_o == ST_OK && bits_q == 16'd46));
endmodule

bind swd_host_xfer swd_host_xfer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_read_i  (req_read_i),
  .req_ap_i    (req_ap_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_status_o(rsp_status_o),
  .swclk_en_o  (swclk_en_o),
  .swdio_o     (swdio_o),
  .swdio_oe_o  (swdio_oe_o)
);

// File: tb/sim_swd_host_xfer.sv
`timescale 1ns/1ps
module sim_swd_host_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ap = 1'b0, req_read = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  idle_cycles = '0;
  logic        req_ready, rsp_valid, swclk_en, swdio_out, swdio_oe;
  logic        swdio_in = 1'b1;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  swd_host_xfer u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_ap_i(req_ap), .req_read_i(req_read), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .idle_cycles_i(idle_cycles),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_rdata_o(rsp_rdata),
    .swclk_en_o(swclk_en), .swdio_o(swdio_out), .swdio_oe_o(swdio_oe), .swdio_i(swdio_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input bit ap, input bit rd, input logic [1:0] addr,
                      input logic [2:0] ack, input bit bad_par, input logic [7:0] idle,
                      input logic [31:0] wdat, input logic [31:0] rdat);
    logic [7:0]  hdr_seen = '0, hdr_exp;
    logic [32:0] w_seen = '0;
    logic [31:0] rdata_got = '0;
    logic [1:0]  stat_got = '0, stat_exp;
    int k = 0, oe_bad = 0, pad_bad = 0, busy_ready = 0, first_bad = -1;
    bit done = 0, tsel, dphase;
    int len_exp;
    tsel = !ap && !rd && addr == 2'b11;
    dphase = tsel || ack == 3'b001;
    if (tsel) stat_exp = 2'b00;
    else if (ack == 3'b001) stat_exp = (rd && bad_par) ? 2'b11 : 2'b00;
    else if (ack == 3'b010) stat_exp = 2'b01;
    else if (ack == 3'b100) stat_exp = 2'b10;
    else stat_exp = 2'b11;
    len_exp = dphase ? 46 + ((ap && stat_exp == 2'b00) ? int'(idle) : 0) : 13;
    hdr_exp = {1'b1, 1'b0, ^{ap, rd, addr}, addr[1], addr[0], rd, ap, 1'b1};

    @(negedge clk);
    req_valid = 1'b1; req_ap = ap; req_read = rd; req_addr = addr;
    req_wdata = wdat; idle_cycles = idle;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && k < 400) begin
      if (rsp_valid) begin
        done = 1; rdata_got = rsp_rdata; stat_got = rsp_status;
      end else if (swclk_en) begin
        bit oe_exp;
        if (k >= 9 && k <= 11) swdio_in = ack[k-9];
        else if (rd && k >= 12 && k <= 43) swdio_in = rdat[k-12];
        else if (rd && k == 44) swdio_in = (^rdat) ^ bad_par;
        else swdio_in = 1'b1;
        oe_exp = !((k >= 8 && k <= 12) || (rd && dphase && k >= 8 && k <= 45));
        if (swdio_oe !== oe_exp) begin oe_bad++; if (first_bad < 0) first_bad = k; end
        if (k < 8) hdr_seen[k] = swdio_out;
        if (!rd && k >= 13 && k <= 45) w_seen[k-13] = swdio_out;
        if (k >= 46 && swdio_out !== 1'b0) pad_bad++;
        if (req_ready) busy_ready++;
        k++;
      end
      @(negedge clk);
    end
    chk(done, "R9", "response seen", 64'(done), 64'd1);
    chk(hdr_seen == hdr_exp, "R1", "header bits", 64'(hdr_seen), 64'(hdr_exp));
    chk(oe_bad == 0, "R2", "oe pattern mismatches (first bit)", 64'(first_bad), 64'hffff);
    chk(stat_got == stat_exp, tsel ? "R7" : "R3", "status", 64'(stat_got), 64'(stat_exp));
    if (dphase)
      chk(k == len_exp, (ap && stat_exp == 2'b00) ? "R8" : (rd ? "R5" : "R6"),
          "transfer length", 64'(k), 64'(len_exp));
    else
      chk(k == len_exp, "R4", "short transfer length", 64'(k), 64'(len_exp));
    if (!rd && dphase)
      chk(w_seen == {^wdat, wdat}, tsel ? "R7" : "R6", "write data on wire",
          64'(w_seen), 64'({^wdat, wdat}));
    if (rd && dphase && !bad_par)
      chk(rdata_got == rdat, "R5", "read data", 64'(rdata_got), 64'(rdat));
    if (ap && dphase && idle != 0)
      chk(pad_bad == 0, "R8", "idle bits low", 64'(pad_bad), 64'd0);
    chk(busy_ready == 0 && !rsp_valid && req_ready, "R9", "pulse and ready",
        64'({busy_ready[7:0], rsp_valid, req_ready}), 64'(1));
  endtask

  initial begin
    logic [2:0] acks [5];
    acks[0] = 3'b001; acks[1] = 3'b010; acks[2] = 3'b100; acks[3] = 3'b111; acks[4] = 3'b000;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !swclk_en && swdio_oe && !swdio_out, "R9", "reset state",
        64'({req_ready, rsp_valid, swclk_en, swdio_oe, swdio_out}), 64'b10010);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 80; n++) begin
      xfer(n[4], n[3], n[2:1] ^ {n[0], 1'b0}, acks[(n / 16) % 5], 1'b0,
           8'((n % 4) * 2 + ((n % 7 == 0) ? 1 : 0)),
           32'h9e3779b9 * (n + 1), 32'h7f4a7c15 ^ (32'(n) * 32'h01000193));
    end
    // full sweep of port/direction/address against every acknowledge
    for (int a = 0; a < 5; a++)
      for (int m = 0; m < 16; m++)
        xfer(m[3], m[2], m[1:0], acks[a], 1'b0, 8'(m % 3),
             32'hc2b2ae35 + 32'(m * 977), 32'h85ebca6b - 32'(m * 131));
    // read parity error: R5
    for (int m = 0; m < 8; m++)
      xfer(m[2], 1'b1, m[1:0], 3'b001, 1'b1, 8'd3, '0, 32'h0f0f_0000 | 32'(m));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule